// File: doc/BRIEF.md
# Transmit Message Queue Controller

This block keeps the bookkeeping for a circular queue of outgoing frames in a CAN-style controller. Software fills a slot in message storage (held outside this block), then pulses an increment command to hand that slot over. The controller tracks the tail (next slot to fill), the head (slot the transmitter sends next) and the occupancy. It also holds the send request and the retry counting, and it raises interrupts when retries run out, when the queue is empty and when the queue has room.

A single control word sets the depth (1 to 32 slots), the payload size per slot, the frame priority, the retry policy and the interrupt enables. A status word reports the pointers, the occupancy and three sticky event flags. On the transmitter side the block presents the head slot index, the payload size and the priority, plus a pending flag. It takes back one-cycle success and failure pulses.

Top module: `txq_ctrl`

## Requirements
- R1: The slot count is the 5-bit depth field (control bits [4:0]) plus one. Status bits [5:0] give occupancy, [12:8] the head index and [20:16] the tail index. Status bit 24 is 1 when occupancy is 0, and status bit 25 is 1 when occupancy equals the slot count. Occupancy never exceeds the slot count.
- R2: `tx_payload_bytes` follows control bits [7:5]: codes 0 to 7 give 8, 12, 16, 20, 24, 32, 48 and 64 bytes. `tx_prio` follows control bits [12:8].
- R3: Control byte 0 (depth and payload code) is written only while `op_mode` is 3'b100, and writes in any other mode leave it unchanged. An accepted byte-0 write also empties the queue and zeroes both pointers.
- R4: Writing 1 to control bit 16 empties the queue, zeroes both pointers and clears the send request. The bit reads 1 on the next read and 0 one cycle later.
- R5: Writing 1 to control bit 17 advances the tail by one slot, wrapping after the last slot, and adds one to occupancy. The bit always reads 0.
- R6: An increment while the queue is full changes nothing and sets sticky status bit 27.
- R7: Control bit 18 is the send request. `tx_pending` is 1 exactly when the request is set and the queue is not empty. An accepted `tx_ok` advances the head and lowers occupancy by one. The request clears itself when the last queued slot is sent.
- R8: Writing 0 to control bit 18 while it is 1 aborts: the request clears, sticky status bit 28 is set, and the pointers are kept.
- R9: The retry code is control bits [14:13] and is used only while `retry_en` is 1; otherwise failures repeat without limit. Code 00 exhausts on the first failure, 01 on the fourth consecutive failure, and 10 or 11 never exhaust. A success restarts the count.
- R10: On exhaustion the head slot is dropped (head advances, occupancy falls by one), the request clears and sticky status bit 26 is set. Writing 1 to status bits 26, 27 or 28 clears that flag.
- R11: Control bit 19 always reads 1.
- R12: One cycle after the state changes, `irq_exhausted` equals enable bit 24 AND status bit 26, `irq_empty` equals enable bit 25 AND empty, and `irq_not_full` equals enable bit 26 AND not full.
- R13: An increment and an accepted `tx_ok` in the same cycle advance both pointers and leave occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_mode | input | 3 | Controller operating mode; 3'b100 is configuration |
| retry_en | input | 1 | Global enable for the retry limit code |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 selects control word, 1 selects status word |
| bus_be | input | 4 | Byte enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data of the word selected one cycle earlier |
| tx_ok | input | 1 | Head message sent successfully |
| tx_fail | input | 1 | Head message attempt failed |
| tx_pending | output | 1 | A message is requested and available |
| tx_head_idx | output | 5 | Slot index of the head message |
| tx_payload_bytes | output | 7 | Payload size per slot in bytes |
| tx_prio | output | 5 | Frame priority |
| irq_exhausted | output | 1 | Retry-exhausted interrupt |
| irq_empty | output | 1 | Queue-empty interrupt |
| irq_not_full | output | 1 | Queue-not-full interrupt |

## Verification
The risky coincidence is a software increment landing in the same cycle as a transmitter success. Both update the occupancy counter, and a design that lets one path override the other loses or invents a message. The bench drives an increment write and a `tx_ok` pulse in one cycle on a partly filled queue. It then reads the status word and expects both pointers to have moved while the occupancy stays the same. A separate case fills the queue and sends one more increment, and the status word must be unchanged except for the overflow flag.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int BUS_W  = 32;
  localparam int PRIO_W = 5;
  localparam int PL_W   = 7;
  localparam logic [2:0] MODE_CFG = 3'b100;

  // control word bit positions
  localparam int C_PL_LO   = 5;
  localparam int C_PRIO_LO = 8;
  localparam int C_RTY_LO  = 13;
  localparam int C_FRES    = 16;
  localparam int C_INCR    = 17;
  localparam int C_SEND    = 18;
  localparam int C_TXEN    = 19;
  localparam int C_IE_EXH  = 24;
  localparam int C_IE_EMP  = 25;
  localparam int C_IE_NF   = 26;

  // status word bit positions
  localparam int S_HEAD_LO = 8;
  localparam int S_TAIL_LO = 16;
  localparam int S_EMPTY   = 24;
  localparam int S_FULL    = 25;
  localparam int S_EXH     = 26;
  localparam int S_OVF     = 27;
  localparam int S_ABORT   = 28;

  typedef enum logic [1:0] {
    RTY_NONE  = 2'b00,
    RTY_THREE = 2'b01,
    RTY_INF_A = 2'b10,
    RTY_INF_B = 2'b11
  } rty_code_e;

  function automatic logic [PL_W-1:0] pl_bytes(input logic [2:0] code);
    logic [PL_W-1:0] r;
    case (code)
      3'd5:    r = 7'd32;
      3'd6:    r = 7'd48;
      3'd7:    r = 7'd64;
      default: r = 7'd8 + {2'b00, code, 2'b00};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/txq_ptrs.sv
module txq_ptrs #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  logic [IDX_W-1:0] depth_m1,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [IDX_W:0]   occ,
  output logic             empty,
  output logic             full,
  output logic             ovf_evt,
  output logic             drained
);
  localparam int OCC_W = IDX_W + 1;

  logic [OCC_W-1:0] slots;
  logic             push_ok;
  logic             pop_ok;

  assign slots   = {1'b0, depth_m1} + OCC_W'(1);
  assign empty   = (occ == '0);
  assign full    = (occ == slots);
  assign push_ok = push & ~full & ~clr;
  assign pop_ok  = pop & ~empty & ~clr;
  assign ovf_evt = push & full & ~clr;
  assign drained = pop_ok & ~push_ok & (occ == OCC_W'(1));

  function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] p,
                                                input logic [IDX_W-1:0] last);
    return (p == last) ? '0 : p + IDX_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      head <= '0;
      tail <= '0;
      occ  <= '0;
    end else begin
      if (push_ok) tail <= wrap_inc(tail, depth_m1);
      if (pop_ok)  head <= wrap_inc(head, depth_m1);
      case ({push_ok, pop_ok})
        2'b10:   occ <= occ + OCC_W'(1);
        2'b01:   occ <= occ - OCC_W'(1);
        default: occ <= occ;
      endcase
    end
  end
endmodule

// File: rtl/txq_retry.sv
module txq_retry #(
  parameter int RETRY_LIM = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       ok,
  input  logic       fail,
  input  logic       rty_en,
  input  logic [1:0] code,
  output logic       exhaust
);
  import txq_pkg::*;
  localparam int CNT_W = $clog2(RETRY_LIM + 1);

  logic [CNT_W-1:0] cnt;
  logic             limited;

  assign limited = rty_en & ~code[1];
  assign exhaust = fail & limited &
                   ((code == RTY_NONE) || (cnt == CNT_W'(RETRY_LIM)));

  always_ff @(posedge clk) begin
    if (rst || clr || ok || exhaust) cnt <= '0;
    else if (fail && limited)        cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/txq_regs.sv
module txq_regs #(
  parameter int IDX_W = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_we,
  input  logic                       bus_addr,
  input  logic [3:0]                 bus_be,
  input  logic [txq_pkg::BUS_W-1:0]  bus_wdata,
  input  logic [2:0]                 op_mode,
  input  logic                       q_clr,
  input  logic                       drained,
  input  logic                       exhaust,
  input  logic                       ovf_evt,
  output logic [IDX_W-1:0]           depth_m1,
  output logic [2:0]                 pl_code,
  output logic [txq_pkg::PRIO_W-1:0] prio,
  output logic [1:0]                 rty_code,
  output logic                       ie_exh,
  output logic                       ie_emp,
  output logic                       ie_nf,
  output logic                       send_q,
  output logic                       fres_q,
  output logic                       incr_cmd,
  output logic                       cfg_wr,
  output logic                       abort_evt,
  output logic                       exh_flag,
  output logic                       ovf_flag,
  output logic                       abort_flag,
  output logic [txq_pkg::BUS_W-1:0]  ctrl_rd
);
  import txq_pkg::*;

  logic wr_ctrl, wr_stat, b2_wr, send_set, fres_set, w1c;

  assign wr_ctrl   = bus_we & ~bus_addr;
  assign wr_stat   = bus_we & bus_addr;
  assign cfg_wr    = wr_ctrl & bus_be[0] & (op_mode == MODE_CFG);
  assign b2_wr     = wr_ctrl & bus_be[2];
  assign incr_cmd  = b2_wr & bus_wdata[C_INCR];
  assign fres_set  = b2_wr & bus_wdata[C_FRES];
  assign send_set  = b2_wr & bus_wdata[C_SEND];
  assign abort_evt = b2_wr & ~bus_wdata[C_SEND] & send_q;
  assign w1c       = wr_stat & bus_be[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      depth_m1 <= '0;
      pl_code  <= '0;
      prio     <= '0;
      rty_code <= RTY_INF_B;
      ie_exh   <= 1'b0;
      ie_emp   <= 1'b0;
      ie_nf    <= 1'b0;
      fres_q   <= 1'b0;
      send_q   <= 1'b0;
    end else begin
      if (cfg_wr) begin
        depth_m1 <= bus_wdata[IDX_W-1:0];
        pl_code  <= bus_wdata[C_PL_LO +: 3];
      end
      if (wr_ctrl && bus_be[1]) begin
        prio     <= bus_wdata[C_PRIO_LO +: PRIO_W];
        rty_code <= bus_wdata[C_RTY_LO +: 2];
      end
      if (wr_ctrl && bus_be[3]) begin
        ie_exh <= bus_wdata[C_IE_EXH];
        ie_emp <= bus_wdata[C_IE_EMP];
        ie_nf  <= bus_wdata[C_IE_NF];
      end
      if (fres_q)        fres_q <= 1'b0;
      else if (fres_set) fres_q <= 1'b1;

      if (q_clr || exhaust || abort_evt) send_q <= 1'b0;
      else if (send_set)                 send_q <= 1'b1;
      else if (drained)                  send_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exh_flag   <= 1'b0;
      ovf_flag   <= 1'b0;
      abort_flag <= 1'b0;
    end else begin
      if (exhaust)                     exh_flag <= 1'b1;
      else if (w1c && bus_wdata[S_EXH]) exh_flag <= 1'b0;
      if (ovf_evt)                     ovf_flag <= 1'b1;
      else if (w1c && bus_wdata[S_OVF]) ovf_flag <= 1'b0;
      if (abort_evt)                   abort_flag <= 1'b1;
      else if (w1c && bus_wdata[S_ABORT]) abort_flag <= 1'b0;
    end
  end

  always_comb begin
    ctrl_rd                     = '0;
    ctrl_rd[IDX_W-1:0]          = depth_m1;
    ctrl_rd[C_PL_LO +: 3]       = pl_code;
    ctrl_rd[C_PRIO_LO +: PRIO_W] = prio;
    ctrl_rd[C_RTY_LO +: 2]      = rty_code;
    ctrl_rd[C_FRES]             = fres_q;
    ctrl_rd[C_SEND]             = send_q;
    ctrl_rd[C_TXEN]             = 1'b1;
    ctrl_rd[C_IE_EXH]           = ie_exh;
    ctrl_rd[C_IE_EMP]           = ie_emp;
    ctrl_rd[C_IE_NF]            = ie_nf;
  end
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl #(
  parameter int IDX_W     = 5,
  parameter int RETRY_LIM = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [2:0]                 op_mode,
  input  logic                       retry_en,
  input  logic                       bus_we,
  input  logic                       bus_addr,
  input  logic [3:0]                 bus_be,
  input  logic [txq_pkg::BUS_W-1:0]  bus_wdata,
  output logic [txq_pkg::BUS_W-1:0]  bus_rdata,
  input  logic                       tx_ok,
  input  logic                       tx_fail,
  output logic                       tx_pending,
  output logic [IDX_W-1:0]           tx_head_idx,
  output logic [txq_pkg::PL_W-1:0]   tx_payload_bytes,
  output logic [txq_pkg::PRIO_W-1:0] tx_prio,
  output logic                       irq_exhausted,
  output logic                       irq_empty,
  output logic                       irq_not_full
);
  import txq_pkg::*;
  localparam int OCC_W = IDX_W + 1;

  logic [IDX_W-1:0]  depth_m1, head, tail;
  logic [OCC_W-1:0]  occ;
  logic [2:0]        pl_code;
  logic [1:0]        rty_code;
  logic              ie_exh, ie_emp, ie_nf;
  logic              send_q, fres_q, incr_cmd, cfg_wr, abort_evt;
  logic              exh_flag, ovf_flag, abort_flag;
  logic              empty, full, ovf_evt, drained, exhaust;
  logic              q_clr, ok_acc, fail_acc, pop;
  logic [BUS_W-1:0]  ctrl_rd, stat_rd;

  assign q_clr    = fres_q | cfg_wr;
  assign ok_acc   = tx_ok & tx_pending;
  assign fail_acc = tx_fail & tx_pending & ~tx_ok;
  assign pop      = ok_acc | exhaust;

  txq_regs #(.IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .op_mode(op_mode),
    .q_clr(q_clr), .drained(drained), .exhaust(exhaust), .ovf_evt(ovf_evt),
    .depth_m1(depth_m1), .pl_code(pl_code), .prio(tx_prio),
    .rty_code(rty_code), .ie_exh(ie_exh), .ie_emp(ie_emp), .ie_nf(ie_nf),
    .send_q(send_q), .fres_q(fres_q), .incr_cmd(incr_cmd), .cfg_wr(cfg_wr),
    .abort_evt(abort_evt), .exh_flag(exh_flag), .ovf_flag(ovf_flag),
    .abort_flag(abort_flag), .ctrl_rd(ctrl_rd)
  );

  txq_ptrs #(.IDX_W(IDX_W)) u_ptrs (
    .clk(clk), .rst(rst), .clr(q_clr), .push(incr_cmd), .pop(pop),
    .depth_m1(depth_m1), .head(head), .tail(tail), .occ(occ),
    .empty(empty), .full(full), .ovf_evt(ovf_evt), .drained(drained)
  );

  txq_retry #(.RETRY_LIM(RETRY_LIM)) u_retry (
    .clk(clk), .rst(rst), .clr(q_clr | abort_evt), .ok(ok_acc),
    .fail(fail_acc), .rty_en(retry_en), .code(rty_code), .exhaust(exhaust)
  );

  assign tx_pending       = send_q & ~empty;
  assign tx_head_idx      = head;
  assign tx_payload_bytes = pl_bytes(pl_code);

  always_comb begin
    stat_rd                      = '0;
    stat_rd[OCC_W-1:0]           = occ;
    stat_rd[S_HEAD_LO +: IDX_W]  = head;
    stat_rd[S_TAIL_LO +: IDX_W]  = tail;
    stat_rd[S_EMPTY]             = empty;
    stat_rd[S_FULL]              = full;
    stat_rd[S_EXH]               = exh_flag;
    stat_rd[S_OVF]               = ovf_flag;
    stat_rd[S_ABORT]             = abort_flag;
  end

  always_ff @(posedge clk) begin
    bus_rdata <= bus_addr ? stat_rd : ctrl_rd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_exhausted <= 1'b0;
      irq_empty     <= 1'b0;
      irq_not_full  <= 1'b0;
    end else begin
      irq_exhausted <= ie_exh & exh_flag;
      irq_empty     <= ie_emp & empty;
      irq_not_full  <= ie_nf & ~full;
    end
  end
endmodule

// File: rtl/txq_ctrl_chk.sv
module txq_ctrl_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       op_mode,
  input logic             bus_we,
  input logic             bus_addr,
  input logic [3:0]       bus_be,
  input logic [31:0]      bus_rdata,
  input logic [IDX_W-1:0] depth_m1,
  input logic [IDX_W:0]   occ,
  input logic             full,
  input logic             incr_cmd,
  input logic             pop,
  input logic             q_clr,
  input logic             fres_q,
  input logic             send_q,
  input logic             drained,
  input logic             abort_evt,
  input logic             tx_pending
);
  assert_occ_bound_R1: assert property (@(posedge clk) disable iff (rst)
    occ <= ({1'b0, depth_m1} + (IDX_W+1)'(1)));

  assert_cfg_lock_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !bus_addr && bus_be[0] && op_mode != 3'b100) |=> $stable(depth_m1));

  assert_fres_selfclear_R4: assert property (@(posedge clk) disable iff (rst)
    fres_q |=> !fres_q);

  assert_full_incr_R6: assert property (@(posedge clk) disable iff (rst)
    (incr_cmd && full && !pop && !q_clr) |=> $stable(occ));

  assert_drain_clears_R7: assert property (@(posedge clk) disable iff (rst)
    drained |=> !send_q);

  assert_pending_nonempty_R7: assert property (@(posedge clk) disable iff (rst)
    tx_pending |-> (occ != '0));

  assert_abort_clears_R8: assert property (@(posedge clk) disable iff (rst)
    abort_evt |=> !send_q);

  assert_txen_reads_one_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_addr) |-> bus_rdata[19]);
endmodule

bind txq_ctrl txq_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .op_mode(op_mode), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_be(bus_be), .bus_rdata(bus_rdata),
  .depth_m1(depth_m1), .occ(occ), .full(full), .incr_cmd(incr_cmd),
  .pop(pop), .q_clr(q_clr), .fres_q(fres_q), .send_q(send_q),
  .drained(drained), .abort_evt(abort_evt), .tx_pending(tx_pending)
);

// File: tb/test_txq_ctrl.sv
`timescale 1ns/1ps
module test_txq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_mode = 3'b000;
  logic        retry_en = 1'b0;
  logic        bus_we = 1'b0;
  logic        bus_addr = 1'b0;
  logic [3:0]  bus_be = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_ok = 1'b0, tx_fail = 1'b0;
  logic        tx_pending;
  logic [4:0]  tx_head_idx;
  logic [6:0]  tx_payload_bytes;
  logic [4:0]  tx_prio;
  logic        irq_exhausted, irq_empty, irq_not_full;

  txq_ctrl i_txq_ctrl (
    .clk(clk), .rst(rst), .op_mode(op_mode), .retry_en(retry_en),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_ok(tx_ok),
    .tx_fail(tx_fail), .tx_pending(tx_pending), .tx_head_idx(tx_head_idx),
    .tx_payload_bytes(tx_payload_bytes), .tx_prio(tx_prio),
    .irq_exhausted(irq_exhausted), .irq_empty(irq_empty),
    .irq_not_full(irq_not_full)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int          kind;
    logic [31:0] mask;
    logic [31:0] exp;
    string       tag;
    int          at;
  } item_t;

  item_t sb[$];
  item_t cur;
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  logic [31:0] port_vec, obs;

  always @(posedge clk) cyc <= cyc + 1;

  // port view: [6:0] payload, [12:8] prio, [20:16] head, 24 pending, 25..27 irqs
  always_comb begin
    port_vec        = '0;
    port_vec[6:0]   = tx_payload_bytes;
    port_vec[12:8]  = tx_prio;
    port_vec[20:16] = tx_head_idx;
    port_vec[24]    = tx_pending;
    port_vec[25]    = irq_exhausted;
    port_vec[26]    = irq_empty;
    port_vec[27]    = irq_not_full;
  end

  // monitor: pops expected items when they fall due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      cur = sb.pop_front();
      obs = (cur.kind == 0) ? bus_rdata : port_vec;
      checks++;
      if ((obs & cur.mask) !== (cur.exp & cur.mask)) begin
        errors++;
        $display("FAIL %s: actual %h expected %h (mask %h)",
                 cur.tag, obs & cur.mask, cur.exp & cur.mask, cur.mask);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual cycle %0d expected below 20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic push_exp(input int kind, input logic [31:0] m,
                          input logic [31:0] e, input string tag);
    item_t it;
    it.kind = kind; it.mask = m; it.exp = e; it.tag = tag; it.at = cyc + 1;
    sb.push_back(it);
  endtask

  task automatic wr(input logic a, input logic [3:0] be, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_be = 4'h0; bus_wdata = '0;
  endtask

  task automatic rd(input logic a, input logic [31:0] m, input logic [31:0] e,
                    input string tag);
    bus_addr = a;
    push_exp(0, m, e, tag);
    @(negedge clk);
  endtask

  task automatic chk_port(input logic [31:0] m, input logic [31:0] e,
                          input string tag);
    push_exp(1, m, e, tag);
    @(negedge clk);
  endtask

  task automatic tx(input logic ok, input logic fail);
    tx_ok = ok; tx_fail = fail;
    @(negedge clk);
    tx_ok = 1'b0; tx_fail = 1'b0;
  endtask

  function automatic logic [31:0] exp_pl(input int c);
    if (c < 5) return 32'(8 + 4 * c);
    if (c == 5) return 32'd32;
    if (c == 6) return 32'd48;
    return 32'd64;
  endfunction

  localparam logic [31:0] INCR  = 32'h0002_0000;
  localparam logic [31:0] SEND  = 32'h0004_0000;
  localparam logic [31:0] FRES  = 32'h0001_0000;
  localparam logic [31:0] LOW26 = 32'h03FF_FFFF;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    rd(1'b0, 32'hFFFF_FFFF, 32'h0008_6000, "R11 reset control word");
    rd(1'b1, 32'hFFFF_FFFF, 32'h0100_0000, "R1 reset status empty");
    chk_port(32'h0F1F_1F7F, 32'h0000_0008, "R2 reset port view");

    // R3: byte 0 locked outside configuration mode
    wr(1'b0, 4'b0001, 32'h0000_00A3);
    rd(1'b0, 32'h0000_00FF, 32'h0, "R3 byte0 write ignored outside config");

    // R2: payload code mapping across all codes
    op_mode = 3'b100;
    for (int c = 0; c < 8; c++) begin
      wr(1'b0, 4'b0001, 32'(3 + (c << 5)));
      chk_port(32'h0000_007F, exp_pl(c), $sformatf("R2 payload code %0d", c));
    end
    wr(1'b0, 4'b0011, 32'h0000_27A3);
    rd(1'b0, 32'h0000_FFFF, 32'h0000_27A3, "R3 config write accepted");
    chk_port(32'h0000_1F7F, 32'h0000_0720, "R2 payload 32 and priority 7");
    op_mode = 3'b000;
    retry_en = 1'b1;

    // R5, R1: four increments fill a 4-slot queue, tail wraps
    repeat (4) wr(1'b0, 4'b0100, INCR);
    rd(1'b1, 32'hFFFF_FFFF, 32'h0200_0004, "R5 four increments, full, tail wrapped");
    rd(1'b0, 32'h0002_0000, 32'h0, "R5 increment bit reads 0");

    // R6: increment while full
    wr(1'b0, 4'b0100, INCR);
    rd(1'b1, 32'hFFFF_FFFF, 32'h0A00_0004, "R6 increment when full rejected");
    wr(1'b1, 4'b1000, 32'h0800_0000);
    rd(1'b1, 32'hFFFF_FFFF, 32'h0200_0004, "R10 overflow flag write-1-clear");

    // R7: send and one success
    wr(1'b0, 4'b0100, SEND);
    chk_port(32'h011F_0000, 32'h0100_0000, "R7 pending with head 0");
    tx(1'b1, 1'b0);
    rd(1'b1, 32'hFFFF_FFFF, 32'h0000_0103, "R7 success advances head");

    // R13: increment and success in one cycle
    bus_we = 1'b1; bus_addr = 1'b0; bus_be = 4'b0100; bus_wdata = INCR | SEND;
    tx_ok = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_be = 4'h0; bus_wdata = '0; tx_ok = 1'b0;
    rd(1'b1, 32'hFFFF_FFFF, 32'h0001_0203, "R13 simultaneous push and pop");

    // R9 code 01: three failures kept, fourth exhausts (R10)
    repeat (3) tx(1'b0, 1'b1);
    rd(1'b1, 32'hFFFF_FFFF, 32'h0001_0203, "R9 three failures keep head");
    tx(1'b0, 1'b1);
    rd(1'b1, 32'hFFFF_FFFF, 32'h0401_0302, "R10 fourth failure drops head");
    rd(1'b0, SEND, 32'h0, "R10 exhaustion clears send request");
    chk_port(32'h0100_0000, 32'h0, "R10 nothing pending after exhaustion");

    // R12: interrupt enables
    wr(1'b0, 4'b1000, 32'h0500_0000);
    chk_port(32'h0E00_0000, 32'h0A00_0000, "R12 exhausted and not-full irqs");
    wr(1'b1, 4'b1000, 32'h0400_0000);
    chk_port(32'h0E00_0000, 32'h0800_0000, "R12 irq follows cleared flag");

    // R8: abort
    wr(1'b0, 4'b0100, SEND);
    wr(1'b0, 4'b0100, 32'h0);
    rd(1'b1, 32'hFFFF_FFFF, 32'h1001_0302, "R8 abort keeps pointers, sets flag");
    rd(1'b0, SEND, 32'h0, "R8 abort clears send request");

    // R9: global enable low gives unlimited retries
    retry_en = 1'b0;
    wr(1'b0, 4'b0100, SEND);
    repeat (6) tx(1'b0, 1'b1);
    rd(1'b1, 32'h0FFF_FFFF, 32'h0001_0302, "R9 retry_en low never exhausts");

    // R9: code 00 exhausts on first failure
    retry_en = 1'b1;
    wr(1'b0, 4'b0010, 32'h0000_0700);
    tx(1'b0, 1'b1);
    rd(1'b1, 32'h0FFF_FFFF, 32'h0401_0001, "R9 code 00 exhausts at once");

    // R9: code 10 unlimited, then drain clears request (R7)
    wr(1'b0, 4'b0010, 32'h0000_4700);
    wr(1'b0, 4'b0100, SEND);
    repeat (5) tx(1'b0, 1'b1);
    rd(1'b1, 32'h0000_00FF, 32'h0000_0001, "R9 code 10 never exhausts");
    tx(1'b1, 1'b0);
    rd(1'b1, LOW26, 32'h0101_0100, "R7 last success empties queue");
    rd(1'b0, SEND, 32'h0, "R7 send request cleared on drain");

    // R4: queue reset command
    repeat (2) wr(1'b0, 4'b0100, INCR);
    wr(1'b0, 4'b0100, SEND);
    wr(1'b0, 4'b0100, FRES);
    rd(1'b0, FRES | SEND, FRES, "R4 reset bit reads 1 first");
    rd(1'b0, FRES | SEND, 32'h0, "R4 reset bit self-clears, send cleared");
    rd(1'b1, LOW26, 32'h0100_0000, "R4 queue emptied");

    // R3: accepted config write empties queue; depth 1 slot
    wr(1'b0, 4'b0100, INCR);
    op_mode = 3'b100;
    wr(1'b0, 4'b0001, 32'h0000_0000);
    op_mode = 3'b000;
    rd(1'b1, LOW26, 32'h0100_0000, "R3 config write empties queue");
    wr(1'b0, 4'b0100, INCR);
    rd(1'b1, LOW26, 32'h0200_0001, "R1 one-slot queue full after one push");

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule